// File: doc/BRIEF.md
# Three-Rail Power Sequencing Controller

This controller staggers the start-up and shut-down of three supply rails. When the enable input goes high, it releases three supply-enable flags one at a time, lowest first. When enable goes low, it takes them back one at a time in the opposite order. Staggering the rails this way limits inrush current and avoids latch-up between supplies that depend on each other.

All delays are counted in ticks of a slow timebase. The timebase arrives as a one-cycle strobe, so the absolute time per tick is set outside the block. A single polarity input chooses whether a released flag reads high or low. Each flag also has a pull-down enable that models an open-drain driver. The enable input is treated as asynchronous and is resynchronised inside the block.

The first step in either direction waits longer than the steps after it. A reversal of enable partway through a sequence continues from the rail level already reached.

Top module: `rail_sequencer`

## Requirements
- R1: After reset the controller holds every flag, whatever the level of `en`. A held flag reads 0 when `inv`=0 and 1 when `inv`=1.
- R2: On power-up the flags are released strictly in the order flag[1], flag[2], flag[3]. At any time the released set is a prefix: {}, {1}, {1,2} or {1,2,3}.
- R3: The first power-up step releases flag[1] on the clock edge that samples the 10th counted tick after the enable transition.
- R4: Every later step in either direction happens on the edge that samples the 8th counted tick after the previous step. No edge changes more than one flag.
- R5: On power-down the flags are taken back in the order flag[3], flag[2], flag[1]. The first step happens on the 10th counted tick after the disable transition, and released flags never grow while the target is off.
- R6: With `inv`=0 a released flag reads 1 and a held flag reads 0. With `inv`=1 all three flags are inverted. The inversion follows `inv` in the same cycle, with no register.
- R7: flag_pd[i] is 1, meaning pull down, exactly when flag[i] is 0.
- R8: If `en` reverses during a sequence, the new sequence starts from the current level. Power-down starts with the highest released flag, and power-up starts with the lowest held flag. The first step of the new sequence uses the 10-tick delay.
- R9: A tick seen in the transition cycle is not counted. The counter restarts at every step. Ticks arriving while all flags already match the target have no effect.
- R10: `en` passes through a two-flop synchronizer. A level sampled at edge k takes effect as the transition at edge k+2, and ticks are counted from edge k+3 onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle strobe from the slow timebase |
| en | input | 1 | Asynchronous sequencing request: 1 powers up, 0 powers down |
| inv | input | 1 | Polarity select for all flags |
| flag | output | N_FLAGS (3) | Supply-enable flags, index 1 to 3 |
| flag_pd | output | N_FLAGS (3) | Per-flag pull-down enable (open-drain model) |

## Verification
The bench builds the block with its default parameters: three flags, a first delay of 10, a step delay of 8 and two synchronizer stages. Directed phases count exact edge offsets for each step in both directions. They also place a tick in the transition cycle and reverse enable in the middle of both power-up and power-down. A long random phase with sparse ticks, rare enable toggles and polarity flips exercises reversals at every level and ticks arriving while the flags are settled. Each cycle of that phase is compared against a count-down reference model.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
   // Direction the sequencer is heading; also the synchronized request it last accepted.
   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } dir_e;
endpackage

// File: rtl/rseq_sync.sv
module rseq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] pipe;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) pipe[0] <= 1'b0;
               else        pipe[0] <= d;
         end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) pipe[s] <= 1'b0;
               else        pipe[s] <= pipe[s-1];
         end
      end
   endgenerate

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/rseq_timer.sv
module rseq_timer #(
   parameter int FIRST_DLY = 10,
   parameter int STEP_DLY  = 8,
   parameter int CNT_W     = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   input  logic first,
   input  logic tick,
   output logic done
);
   localparam logic [CNT_W-1:0] FIRST_LAST = CNT_W'(FIRST_DLY - 1);
   localparam logic [CNT_W-1:0] STEP_LAST  = CNT_W'(STEP_DLY - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;

   assign last = first ? FIRST_LAST : STEP_LAST;
   assign done = run && tick && (cnt_q == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (clr)            cnt_q <= '0;
      else if (run && tick)    cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/rseq_fsm.sv
module rseq_fsm
   import rseq_pkg::*;
#(
   parameter int N_FLAGS = 3,
   parameter int LVL_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_s,
   input  logic             done,
   output logic [LVL_W-1:0] lvl,
   output dir_e             goal,
   output logic             clr,
   output logic             run,
   output logic             first
);
   localparam logic [LVL_W-1:0] TOP = LVL_W'(N_FLAGS);

   logic [LVL_W-1:0] lvl_q;
   dir_e             goal_q;
   logic             first_q;
   logic             chg;
   logic [LVL_W-1:0] target;

   assign chg    = (en_s != goal_q);
   assign target = (goal_q == DIR_UP) ? TOP : '0;
   assign run    = !chg && (lvl_q != target);
   assign clr    = chg || done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q   <= '0;
         goal_q  <= DIR_DOWN;
         first_q <= 1'b1;
      end else if (chg) begin
         goal_q  <= dir_e'(en_s);
         first_q <= 1'b1;
      end else if (done) begin
         first_q <= 1'b0;
         if (goal_q == DIR_UP) lvl_q <= lvl_q + 1'b1;
         else                  lvl_q <= lvl_q - 1'b1;
      end
   end

   assign lvl   = lvl_q;
   assign goal  = goal_q;
   assign first = first_q;
endmodule

// File: rtl/rseq_outmap.sv
module rseq_outmap #(
   parameter int N_FLAGS = 3,
   parameter int LVL_W   = 2
) (
   input  logic [LVL_W-1:0] lvl,
   input  logic             inv,
   output logic [N_FLAGS:1] flag,
   output logic [N_FLAGS:1] flag_pd
);
   generate
      for (genvar i = 1; i <= N_FLAGS; i++) begin : g_flag
         logic released;
         assign released   = (lvl >= LVL_W'(i));
         assign flag[i]    = released ^ inv;
         assign flag_pd[i] = ~(released ^ inv);
      end
   endgenerate
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
   import rseq_pkg::*;
#(
   parameter int N_FLAGS     = 3,
   parameter int FIRST_DLY   = 10,
   parameter int STEP_DLY    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             en,
   input  logic             inv,
   output logic [N_FLAGS:1] flag,
   output logic [N_FLAGS:1] flag_pd
);
   localparam int MAX_DLY = (FIRST_DLY > STEP_DLY) ? FIRST_DLY : STEP_DLY;
   localparam int CNT_W   = (MAX_DLY < 2) ? 1 : $clog2(MAX_DLY);
   localparam int LVL_W   = $clog2(N_FLAGS + 1);

   generate
      if (N_FLAGS < 1)     begin : g_bad_n     $error("N_FLAGS must be at least 1"); end
      if (FIRST_DLY < 1)   begin : g_bad_first $error("FIRST_DLY must be at least 1"); end
      if (STEP_DLY < 1)    begin : g_bad_step  $error("STEP_DLY must be at least 1"); end
      if (SYNC_STAGES < 2) begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end
   endgenerate

   logic             en_s;
   logic             done;
   logic             clr;
   logic             run;
   logic             first;
   logic [LVL_W-1:0] lvl;
   dir_e             goal_q;

   rseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (en),
      .q     (en_s)
   );

   rseq_timer #(
      .FIRST_DLY (FIRST_DLY),
      .STEP_DLY  (STEP_DLY),
      .CNT_W     (CNT_W)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .run   (run),
      .first (first),
      .tick  (tick),
      .done  (done)
   );

   rseq_fsm #(
      .N_FLAGS (N_FLAGS),
      .LVL_W   (LVL_W)
   ) u_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .en_s  (en_s),
      .done  (done),
      .lvl   (lvl),
      .goal  (goal_q),
      .clr   (clr),
      .run   (run),
      .first (first)
   );

   rseq_outmap #(
      .N_FLAGS (N_FLAGS),
      .LVL_W   (LVL_W)
   ) u_out (
      .lvl     (lvl),
      .inv     (inv),
      .flag    (flag),
      .flag_pd (flag_pd)
   );
endmodule

// File: rtl/rseq_chk.sv
module rseq_chk #(
   parameter int N_FLAGS = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             inv,
   input logic [N_FLAGS:1] flag,
   input logic [N_FLAGS:1] flag_pd,
   input logic             goal
);
   logic [N_FLAGS-1:0] rel;
   assign rel = flag ^ {N_FLAGS{inv}};

   AST_PD_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
      flag_pd == ~flag);                                                   // R7

   AST_PREFIX_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (rel & (rel + 1'b1)) == '0);                                         // R2

   AST_ONE_FLAG_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones(rel ^ $past(rel)) <= 1));                       // R4

   AST_STEP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> (rel == $past(rel)));                                      // R9

   AST_NO_RISE_WHILE_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      !goal |=> ($countones(rel) <= $countones($past(rel))));              // R5

   AST_NO_FALL_WHILE_UP: assert property (@(posedge clk) disable iff (!rst_n)
      goal |=> ($countones(rel) >= $countones($past(rel))));               // R8
endmodule

bind rail_sequencer rseq_chk #(.N_FLAGS(N_FLAGS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick),
   .inv     (inv),
   .flag    (flag),
   .flag_pd (flag_pd),
   .goal    (goal_q)
);

// File: tb/sim_rail_sequencer.sv
module sim_rail_sequencer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       en = 1'b0;
   logic       inv = 1'b0;
   logic [3:1] flag;
   logic [3:1] flag_pd;

   int n_vec = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   rail_sequencer u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .en      (en),
      .inv     (inv),
      .flag    (flag),
      .flag_pd (flag_pd)
   );

   // Reference model: count-down of remaining ticks, from the requirements.
   logic m_s1, m_s2, m_goal;
   int   m_lvl, m_rem;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= 0; m_s2 <= 0; m_goal <= 0; m_lvl <= 0; m_rem <= 10;
      end else begin
         m_s1 <= en;
         m_s2 <= m_s1;
         if (m_s2 != m_goal) begin
            m_goal <= m_s2;
            m_rem  <= 10;
         end else if (tick && (m_lvl != (m_goal ? 3 : 0))) begin
            if (m_rem == 1) begin
               m_lvl <= m_goal ? m_lvl + 1 : m_lvl - 1;
               m_rem <= 8;
            end else begin
               m_rem <= m_rem - 1;
            end
         end
      end
   end

   function automatic logic [3:1] exp_flag(int lvl, logic pol);
      logic [3:1] r;
      for (int i = 1; i <= 3; i++) r[i] = (lvl >= i);
      return r ^ {3{pol}};
   endfunction

   task automatic chk(logic [3:1] act, logic [3:1] exp, string req);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc(int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      #1_600_000;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd5150));
      en = 1'b1;                       // enable high during reset must not matter
      cyc(3);
      chk(flag, 3'b000, "R1");
      chk(flag_pd, 3'b111, "R1");
      inv = 1'b1; #1;
      chk(flag, 3'b111, "R1");
      inv = 1'b0;
      en = 1'b0;
      rst_n = 1'b1;
      cyc(5);
      chk(flag, 3'b000, "R1");

      // Power-up with a tick every cycle: R10 sync latency plus R3 first delay
      en = 1'b1; tick = 1'b1;
      cyc(12); chk(flag, 3'b000, "R3");
      cyc(1);  chk(flag, 3'b001, "R10");
      cyc(7);  chk(flag, 3'b001, "R4");
      cyc(1);  chk(flag, 3'b011, "R2");
      cyc(7);  chk(flag, 3'b011, "R4");
      cyc(1);  chk(flag, 3'b111, "R2");
      cyc(20); chk(flag, 3'b111, "R9");   // ticks at target ignored

      inv = 1'b1; #1;
      chk(flag, 3'b000, "R6");
      chk(flag_pd, 3'b111, "R7");
      inv = 1'b0; #1;
      chk(flag_pd, 3'b000, "R7");

      // Power-down
      @(negedge clk);
      en = 1'b0;
      cyc(12); chk(flag, 3'b111, "R5");
      cyc(1);  chk(flag, 3'b011, "R5");
      cyc(7);  chk(flag, 3'b011, "R4");
      cyc(1);  chk(flag, 3'b001, "R5");
      cyc(8);  chk(flag, 3'b000, "R5");

      // Tick only in the transition cycle is not counted
      tick = 1'b0; cyc(5);
      en = 1'b1;
      cyc(2); tick = 1'b1;             // tick during cycle ending at transition edge
      cyc(1); tick = 1'b0;
      cyc(3); tick = 1'b1;
      cyc(9); chk(flag, 3'b000, "R9");
      cyc(1); chk(flag, 3'b001, "R9");
      cyc(8); chk(flag, 3'b011, "R4");

      // Reversal mid power-up: comes down from flag2
      en = 1'b0;
      cyc(12); chk(flag, 3'b011, "R8");
      cyc(1);  chk(flag, 3'b001, "R8");
      // Reversal mid power-down: goes up from flag2
      en = 1'b1;
      cyc(12); chk(flag, 3'b001, "R8");
      cyc(1);  chk(flag, 3'b011, "R8");

      // Random phase against the model
      for (int c = 0; c < 20000; c++) begin
         @(negedge clk);
         chk(flag, exp_flag(m_lvl, inv), m_goal ? "R2" : "R5");
         chk(flag_pd, ~exp_flag(m_lvl, inv), "R7");
         tick = ($urandom % 3) == 0;
         if (($urandom % 97) == 0) en = ~en;
         if (($urandom % 211) == 0) inv = ~inv;
      end

      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule